// File: doc/BRIEF.md
# Debug Register Access Target

This block is the slave end of a debug register bus. The bus uses a four-phase request/acknowledge handshake. A master raises `req` and, in that same cycle, presents a direction bit, an address and write data. The target captures them on the first clock edge that sees `req` high, then raises `ack`. It keeps `ack` high until the master drops `req`. It lowers `ack` on the first clock after it sees `req` low. A new transfer can begin only once `ack` is low again.

The target holds one control register at a parameterised address. A write loads it from `wdata` and a read returns it on `rdata`. After reset the register holds a parameterised value, 4 by default, which marks a stopped state. Every other address is acknowledged and has no effect, and a read of such an address returns zero.

Back-pressure works like this. `ack` is the only flow-control signal. The target stalls the master simply by not yet raising `ack`, and the master frees the target by dropping `req`. `rdata` stays stable for the whole time `ack` is high, and it keeps its value until the next transfer is accepted.

Top module: `dbg_reg_target`

## Requirements
- R1: A synchronous active-high `rst` clears `ack` and `rdata` to zero and sets the control register to `CTRL_RST` (4 by default), which a later read returns.
- R2: When `req` is high and `ack` is low at a clock edge, the transfer is accepted and `ack` is high after that edge.
- R3: While `req` stays high, `ack` stays high and `rdata` does not change.
- R4: At the first clock edge where `req` is low while `ack` is high, `ack` falls.
- R5: A write (`wr_en`=1) to `CTRL_ADDR` (0x10 by default) loads the control register from `wdata`. The target uses only the `addr`, `wr_en` and `wdata` values present at the accepting edge, so later changes while `req` is held have no effect.
- R6: A read (`wr_en`=0) of `CTRL_ADDR` returns the current control register value on `rdata` together with `ack`.
- R7: A write to any address other than `CTRL_ADDR` is acknowledged and leaves the control register unchanged.
- R8: A read of any address other than `CTRL_ADDR` is acknowledged and returns all zeros.
- R9: During the acknowledge of any write, `rdata` is zero.
- R10: If `rst` is high at the same edge that would accept a request, reset wins: no transfer is accepted, `ack` stays low and the register takes its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request from master |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, held while ack is high |
| ack | output | 1 | Acknowledge |

## Verification
Two pairs of events can land on one clock edge. The first is reset arriving together with an accepting request. The bench raises `rst` and a write request to the control address at the same falling edge. It then checks that `ack` never rose, and that a later read returns the reset value, not the written data. The second is a control write being applied at the acceptance edge while the master changes the bus during the held phase. A scoreboard pops the expected read value at every rising `ack`, and this catches both a bus value captured too late and a write that was applied twice.

// File: rtl/dbg_tgt_pkg.sv
package dbg_tgt_pkg;
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_BUSY = 1'b1
  } hs_state_e;
endpackage

// File: rtl/dbg_tgt_handshake.sv
module dbg_tgt_handshake
  import dbg_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept,
  output logic ack
);
  hs_state_e state_q, state_d;

  // a transfer is taken only from idle, so a held req cannot start a second one
  assign accept = req && (state_q == HS_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (req)  state_d = HS_BUSY;
      HS_BUSY: if (!req) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HS_IDLE;
    else     state_q <= state_d;
  end

  assign ack = (state_q == HS_BUSY);
endmodule

// File: rtl/dbg_tgt_decode.sv
module dbg_tgt_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
  input  logic              accept,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_wr,
  output logic              ctrl_rd
);
  logic hit;
  assign hit     = (addr == CTRL_ADDR);
  assign ctrl_wr = accept && wr_en && hit;
  assign ctrl_rd = accept && !wr_en && hit;
endmodule

// File: rtl/dbg_tgt_ctrl_reg.sv
module dbg_tgt_ctrl_reg #(
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] CTRL_RST = 64'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= CTRL_RST;
    else if (load) q <= din;
  end
endmodule

// File: rtl/dbg_tgt_rdpath.sv
module dbg_tgt_rdpath #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sel_ctrl,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata
);
  // loaded only on acceptance: stable for the whole acknowledge and beyond
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (accept) rdata <= sel_ctrl ? ctrl_q : '0;
  end
endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [DATA_W-1:0] CTRL_RST  = 64'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);
  logic              accept;
  logic              ctrl_wr;
  logic              ctrl_rd;
  logic [DATA_W-1:0] ctrl_q;

  dbg_tgt_handshake u_hs (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .accept (accept),
    .ack    (ack)
  );

  dbg_tgt_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_dec (
    .accept  (accept),
    .wr_en   (wr_en),
    .addr    (addr),
    .ctrl_wr (ctrl_wr),
    .ctrl_rd (ctrl_rd)
  );

  dbg_tgt_ctrl_reg #(.DATA_W(DATA_W), .CTRL_RST(CTRL_RST)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .load (ctrl_wr),
    .din  (wdata),
    .q    (ctrl_q)
  );

  dbg_tgt_rdpath #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .sel_ctrl (ctrl_rd),
    .ctrl_q   (ctrl_q),
    .rdata    (rdata)
  );
endmodule

// File: rtl/dbg_reg_target_chk.sv
module dbg_reg_target_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              ack,
  input logic [DATA_W-1:0] ctrl_q
);
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (!ack && rdata == '0));

  a_r2_ack_rise: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> ack);

  a_r3_ack_held: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> (ack && $stable(rdata)));

  a_r4_ack_fall: assert property (@(posedge clk) disable iff (rst)
    (ack && !req) |=> !ack);

  a_r5_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && wr_en && addr == CTRL_ADDR) |=> (ctrl_q == $past(wdata)));

  a_r7_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
    (!(req && !ack && wr_en && addr == CTRL_ADDR)) |=> $stable(ctrl_q));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && !wr_en && addr != CTRL_ADDR) |=> (rdata == '0));

  a_r9_write_zero: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && wr_en) |=> (rdata == '0));
endmodule

bind dbg_reg_target dbg_reg_target_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .ack(ack), .ctrl_q(ctrl_q)
);

// File: tb/dbg_reg_target_test.sv
module dbg_reg_target_test;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam logic [AW-1:0] CA = 8'h10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          ack;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model_ctrl = 64'd4;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          ack_prev = 1'b0;
  logic          done = 1'b0;

  dbg_reg_target uut (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack(ack)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: on every rising ack, compare rdata with the oldest expected item
  always @(negedge clk) begin
    if (ack && !ack_prev) begin
      if (exp_q.size() == 0) check("R10 unexpected ack", 64'd1, 64'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
    ack_prev <= ack;
  end

  // driver: one full four-phase transfer, holding req for hold cycles after ack
  task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int hold, input string tag);
    logic [DW-1:0] seen;
    @(negedge clk);
    req = 1'b1; wr_en = we; addr = a; wdata = d;
    if (we) exp_q.push_back('0);
    else    exp_q.push_back((a == CA) ? model_ctrl : '0);
    tag_q.push_back(tag);
    if (we && a == CA) model_ctrl = d;
    @(negedge clk);
    check("R2 ack after accept", {63'd0, ack}, 64'd1);
    seen = rdata;
    for (int i = 0; i < hold; i++) begin
      wr_en = ~wr_en; addr = CA; wdata = ~wdata;   // late bus changes (R5)
      @(negedge clk);
      check("R3 ack held", {63'd0, ack}, 64'd1);
      check("R3 rdata stable", rdata, seen);
    end
    req = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    @(negedge clk);
    check("R4 ack falls", {63'd0, ack}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack reset", {63'd0, ack}, 64'd0);
    check("R1 rdata reset", rdata, 64'd0);
    rst = 1'b0;
    xfer(1'b0, CA, '0, 2, "R1 R6 ctrl reset value");
    xfer(1'b1, CA, 64'd5, 3, "R5 R9 write ctrl");
    xfer(1'b0, CA, '0, 1, "R6 read ctrl after write");
    xfer(1'b1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7 R9 unmapped write");
    xfer(1'b0, CA, '0, 0, "R7 ctrl unchanged");
    xfer(1'b0, 8'hFF, '0, 2, "R8 unmapped read");
    xfer(1'b0, 8'h11, '0, 0, "R8 unmapped read near ctrl");
    xfer(1'b1, CA, 64'hA5A5_0000_FFFF_1234, 0, "R5 R9 write ctrl pattern");
    xfer(1'b0, CA, '0, 0, "R6 read pattern min gap");
    // R10: reset and an accepting write on the same edge
    @(negedge clk);
    rst = 1'b1; req = 1'b1; wr_en = 1'b1; addr = CA; wdata = 64'h77;
    @(negedge clk);
    rst = 1'b0; req = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    check("R10 no ack under reset", {63'd0, ack}, 64'd0);
    model_ctrl = 64'd4;
    @(negedge clk);
    check("R10 still no ack", {63'd0, ack}, 64'd0);
    xfer(1'b0, CA, '0, 1, "R10 R1 reset value wins");
    repeat (2) @(negedge clk);
    check("R10 scoreboard empty", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule